// File: doc/BRIEF.md
# Conditional-Subtract Restoring Divider

This unit divides a non-negative 16-bit dividend by a non-negative 16-bit divisor. It uses one 32-bit working register. Each clock cycle it performs one conditional-subtract step. The divisor is compared against the register at bit position 15. When the subtraction does not go negative, the register takes the shifted difference with a 1 in the lowest bit. Otherwise it takes the plain shifted old value. After the full number of steps, the quotient bits are in the lower half of the register and the remainder is in the upper half.

A caller loads the operands and a step count with a one-cycle start pulse. In run mode the steps then proceed on consecutive cycles. In single-step mode each step waits for its own step pulse. The register halves are visible at the outputs at all times, so a caller can follow the division step by step.

A dividend with leading zeros may be pre-shifted left by the caller. The step count is then reduced by the same amount, and one leading zero must be kept. Signed operands and any sign-extension setting play no part here.

Top module: `csd_divider`

## Requirements
- R1: After synchronous reset, busy_o, done_o, carry_o and ovf_o are 0, and quot_o and rem_o are 0.
- R2: A start pulse taken while idle loads the register with rem_o = 0 and quot_o = dividend_i, visible on the cycle after the start edge. busy_o is 1 in that cycle when the step count is non-zero.
- R3: Each step forms D = register − divisor·2^15, with the register read as signed 32-bit. If D ≥ 0 the register becomes 2·D + 1. Otherwise it becomes twice its old value. Run mode performs one step per clock.
- R4: For a count N of 1..16, done_o is 1 for exactly one cycle, in the cycle after the edge that performs step N. busy_o is 0 in that cycle, and done_o is 0 in the cycle after it.
- R5: With a dividend and divisor in 1..0x7FFF (dividend 0 allowed) and N = 16, quot_o equals the integer quotient and rem_o equals the remainder at done.
- R6: A dividend a < 2^(15−k), loaded as a·2^k and run with N = 16 − k, gives the same quotient and remainder as R5.
- R7: A count of 0 pulses done_o in the cycle after the start edge without busy_o ever rising. The register and both flags keep their loaded or previous values.
- R8: A start pulse while busy_o is 1 is ignored: the operands are not reloaded and the done timing is unchanged.
- R9: carry_o is 1 after a step with D ≥ 0 and 0 after a step with D < 0. It holds its value between steps.
- R10: ovf_o is 1 when bits 31 and 30 of the value being shifted in the last step differ, meaning the shift lost a significant bit. Otherwise it is 0. It holds its value between steps.
- R11: If step_mode_i is 1 at start, a step is performed only on an edge where step_i is 1. Between step pulses the register, the flags and busy_o hold.
- R12: A count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load operands and begin (ignored while busy) |
| step_mode_i | input | 1 | Sampled at start: 1 selects single-step operation |
| step_i | input | 1 | Step request in single-step operation |
| dividend_i | input | 16 | Dividend, possibly pre-shifted |
| divisor_i | input | 16 | Divisor |
| count_i | input | 5 | Number of steps, 0..16 (larger values clamp) |
| busy_o | output | 1 | Steps remain |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Lower half of the working register |
| rem_o | output | 16 | Upper half of the working register |
| carry_o | output | 1 | Last step did not borrow |
| ovf_o | output | 1 | Last step's shift lost a significant bit |

## Verification
Some properties are checked on every cycle by the assertions. These are the one-cycle done pulse, and that busy and done are never high together. They also cover the count going down by one per step and holding while no step fires, and the register and flags holding between step pulses. Finally, they check that a start during a run reloads nothing and that the low register bit agrees with the carry after every step.

Other behaviour can only be shown by the bench scenarios. This covers whether the arithmetic actually yields the right quotient and remainder over many operand pairs, pre-shifted dividends with shortened counts, the overflow case, count clamping and the zero count.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int unsigned DEF_OPD_W = 16;

    typedef struct packed {
        logic carry;
        logic ovf;
    } csd_flags_t;

endpackage

// File: rtl/csd_step_alu.sv
module csd_step_alu
    import csd_pkg::*;
#(
    parameter int unsigned OPD_W = DEF_OPD_W,
    localparam int unsigned ACC_W = 2 * OPD_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [OPD_W-1:0] dvsr_i,
    output logic [ACC_W-1:0] acc_nx_o,
    output csd_flags_t       flags_o
);

    logic [ACC_W:0]   diff;
    logic             no_borrow;
    logic [ACC_W-1:0] shift_src;

    always_comb begin
        // divisor aligned at bit OPD_W-1, register sign-extended by one bit
        diff      = {acc_i[ACC_W-1], acc_i} - {1'b0, dvsr_i, {(OPD_W-1){1'b0}}};
        no_borrow = ~diff[ACC_W];
        shift_src = no_borrow ? diff[ACC_W-1:0] : acc_i;
        acc_nx_o  = {shift_src[ACC_W-2:0], no_borrow};
        flags_o.carry = no_borrow;
        flags_o.ovf   = shift_src[ACC_W-1] ^ shift_src[ACC_W-2];
    end

endmodule

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl #(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned MAX_STEPS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_mode_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_STEPS);

    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] count_lim;
    logic             mode_q;

    generate
        if (MAX_STEPS >= (1 << CNT_W) - 1) begin : g_no_clamp
            assign count_lim = count_i;
        end else begin : g_clamp
            assign count_lim = (count_i > MAX_CNT) ? MAX_CNT : count_i;
        end
    endgenerate

    assign load_o = start_i & ~busy_o;
    assign fire_o = busy_o & (~mode_q | step_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            left_q <= '0;
            mode_q <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                left_q <= count_lim;
                mode_q <= step_mode_i;
                busy_o <= (count_lim != '0);
                done_o <= (count_lim == '0);
            end else if (fire_o) begin
                left_q <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: never busy and done together
    a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R3: each fired step consumes one count
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> left_q == $past(left_q) - CNT_W'(1));

    // R8: a start during a run neither reloads nor ends it
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !fire_o) |=> (busy_o && $stable(left_q)));

    // R11: single-step operation waits for a step request
    a_r11_wait_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mode_q && !step_i) |=> (busy_o && $stable(left_q)));

endmodule

// File: rtl/csd_divider.sv
module csd_divider
    import csd_pkg::*;
#(
    parameter int unsigned OPD_W     = DEF_OPD_W,
    parameter int unsigned MAX_STEPS = OPD_W,
    localparam int unsigned ACC_W    = 2 * OPD_W,
    localparam int unsigned CNT_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_mode_i,
    input  logic             step_i,
    input  logic [OPD_W-1:0] dividend_i,
    input  logic [OPD_W-1:0] divisor_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [OPD_W-1:0] quot_o,
    output logic [OPD_W-1:0] rem_o,
    output logic             carry_o,
    output logic             ovf_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;
    logic [OPD_W-1:0] dvsr_q;
    csd_flags_t       flags_q;
    csd_flags_t       flags_nx;
    logic             load;
    logic             fire;

    csd_seq_ctrl #(
        .CNT_W     (CNT_W),
        .MAX_STEPS (MAX_STEPS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .step_mode_i (step_mode_i),
        .step_i      (step_i),
        .count_i     (count_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .load_o      (load),
        .fire_o      (fire)
    );

    csd_step_alu #(
        .OPD_W (OPD_W)
    ) u_alu (
        .acc_i    (acc_q),
        .dvsr_i   (dvsr_q),
        .acc_nx_o (acc_nx),
        .flags_o  (flags_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            dvsr_q  <= '0;
            flags_q <= '0;
        end else if (load) begin
            acc_q  <= {{OPD_W{1'b0}}, dividend_i};
            dvsr_q <= divisor_i;
        end else if (fire) begin
            acc_q   <= acc_nx;
            flags_q <= flags_nx;
        end
    end

    assign quot_o  = acc_q[OPD_W-1:0];
    assign rem_o   = acc_q[ACC_W-1:OPD_W];
    assign carry_o = flags_q.carry;
    assign ovf_o   = flags_q.ovf;

    // R2: a taken start clears the upper half and loads the dividend below
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (rem_o == '0 && quot_o == $past(dividend_i)));

    // R3, R9: the inserted quotient bit matches the no-borrow flag
    a_r9_carry_bit: assert property (@(posedge clk) disable iff (rst)
        fire |=> acc_q[0] == carry_o);

    // R11: register holds while a run waits for its next step
    a_r11_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !fire) |=> $stable(acc_q));

    // R9, R10: flags change only on a fired step
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(flags_q));

endmodule

// File: tb/csd_divider_bench.sv
module csd_divider_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        smode = 1'b0;
    logic        stp = 1'b0;
    logic [15:0] dvd = '0;
    logic [15:0] dvs = '0;
    logic [4:0]  cnt = '0;
    logic        busy_o, done_o, carry_o, ovf_o;
    logic [15:0] quot_o, rem_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    csd_divider u_csd_divider (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .step_mode_i (smode),
        .step_i      (stp),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .count_i     (cnt),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quot_o      (quot_o),
        .rem_o       (rem_o),
        .carry_o     (carry_o),
        .ovf_o       (ovf_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // one step from the requirement arithmetic: {ovf, carry, register}
    function automatic logic [33:0] mstep(input logic [31:0] acc, input logic [15:0] d);
        longint sa, diff;
        logic [31:0] src;
        logic ge;
        sa   = acc[31] ? longint'(acc) - 64'sh1_0000_0000 : longint'(acc);
        diff = sa - longint'(d) * 32768;
        ge   = (diff >= 0);
        src  = ge ? diff[31:0] : acc;
        return {src[31] ^ src[30], ge, src[30:0], ge};
    endfunction

    task automatic launch(input logic [15:0] a, input logic [15:0] d, input int n, input logic mode);
        @(negedge clk);
        dvd = a; dvs = d; cnt = n[4:0]; smode = mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // run mode; returns final register and checks latency, pulse, flags
    task automatic run_auto(input logic [15:0] a, input logic [15:0] d, input int n,
                            output logic [31:0] res);
        int lat, steps;
        logic [33:0] m;
        logic c0, v0;
        c0 = carry_o; v0 = ovf_o;
        launch(a, d, n, 1'b0);
        steps = (n > 16) ? 16 : n;
        chk(busy_o == (steps != 0), "R2 busy after start", busy_o, steps != 0);
        lat = 1;
        while (!done_o && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == steps + 1, "R4 done latency", lat, steps + 1);
        chk(!busy_o, "R4 busy low at done", busy_o, 0);
        res = {rem_o, quot_o};
        m = {v0, c0, 16'h0000, a};
        for (int i = 0; i < steps; i++) m = mstep(m[31:0], d);
        chk(res == m[31:0], "R3 register after steps", res, m[31:0]);
        chk(carry_o == m[32], "R9 carry flag", carry_o, m[32]);
        chk(ovf_o == m[33], "R10 overflow flag", ovf_o, m[33]);
        @(negedge clk);
        chk(!done_o, "R4 done is one cycle", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [15:0] a, d, a2;
        logic [33:0] m;
        int lat;
        logic c0, v0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 reset control", {busy_o, done_o}, 0);
        chk(quot_o == 0 && rem_o == 0, "R1 reset register", {rem_o, quot_o}, 0);
        chk(!carry_o && !ovf_o, "R1 reset flags", {carry_o, ovf_o}, 0);

        // R5: random operand pairs, full 16 steps
        for (int i = 0; i < 200; i++) begin
            lcg = nxt(lcg); a = {1'b0, lcg[30:16]};
            lcg = nxt(lcg); d = {1'b0, lcg[30:16]};
            if (i % 4 == 1) d = {12'h000, lcg[19:16]};
            if (d == 0) d = 16'd1;
            run_auto(a, d, 16, r);
            chk(r[15:0] == a / d, "R5 quotient", r[15:0], a / d);
            chk(r[31:16] == a % d, "R5 remainder", r[31:16], a % d);
        end

        // R5: boundary operands
        run_auto(16'h7FFF, 16'h0001, 16, r);
        chk(r == {16'h0000, 16'h7FFF}, "R5 divide by one", r, 32'h7FFF);
        run_auto(16'h7FFE, 16'h7FFF, 16, r);
        chk(r == {16'h7FFE, 16'h0000}, "R5 divisor above dividend", r, 32'h7FFE0000);
        run_auto(16'h0000, 16'h0005, 16, r);
        chk(r == 32'h0, "R5 zero dividend", r, 0);
        run_auto(16'h4321, 16'h4321, 16, r);
        chk(r == 32'h0000_0001, "R5 equal operands", r, 1);

        // R6: pre-shifted dividends with shortened counts
        for (int k = 1; k <= 14; k++) begin
            for (int j = 0; j < 6; j++) begin
                lcg = nxt(lcg);
                a = 16'(lcg[31:16] & ((16'd1 << (15 - k)) - 16'd1));
                lcg = nxt(lcg);
                d = 16'(lcg[31:16] & 16'h00FF);
                if (j == 0) d = 16'h7FFF;
                if (d == 0) d = 16'd3;
                a2 = a << k;
                run_auto(a2, d, 16 - k, r);
                chk(r[15:0] == a / d, "R6 quotient shifted", r[15:0], a / d);
                chk(r[31:16] == a % d, "R6 remainder shifted", r[31:16], a % d);
            end
        end

        // R7: count of zero
        run_auto(16'h0100, 16'h0003, 16, r);
        c0 = carry_o; v0 = ovf_o;
        launch(16'h1234, 16'h0007, 0, 1'b0);
        chk(done_o, "R7 done at once", done_o, 1);
        chk(!busy_o, "R7 no busy", busy_o, 0);
        chk({rem_o, quot_o} == 32'h0000_1234, "R7 register unchanged", {rem_o, quot_o}, 32'h1234);
        chk(carry_o == c0 && ovf_o == v0, "R7 flags unchanged", {carry_o, ovf_o}, {c0, v0});
        @(negedge clk);
        chk(!done_o && !busy_o, "R7 idle after pulse", {busy_o, done_o}, 0);

        // R12: count above the limit acts as full count
        run_auto(16'h5A5A, 16'h0123, 31, r);
        chk(r[15:0] == 16'h5A5A / 16'h0123, "R12 clamped quotient", r[15:0], 16'h5A5A / 16'h0123);
        chk(r[31:16] == 16'h5A5A % 16'h0123, "R12 clamped remainder", r[31:16], 16'h5A5A % 16'h0123);

        // R8: start during a run
        launch(16'h7000, 16'h0031, 16, 1'b0);
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        dvd = 16'h0011; dvs = 16'h0002; cnt = 5'd2; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done_o && lat < 64) begin @(negedge clk); lat++; end
        chk(lat == 17, "R8 timing kept", lat, 17);
        chk(quot_o == 16'h7000 / 16'h0031, "R8 quotient kept", quot_o, 16'h7000 / 16'h0031);
        chk(rem_o == 16'h7000 % 16'h0031, "R8 remainder kept", rem_o, 16'h7000 % 16'h0031);

        // R10: overflow with a zero divisor
        run_auto(16'hFFFF, 16'h0000, 15, r);
        chk(!ovf_o, "R10 no overflow at 15 steps", ovf_o, 0);
        run_auto(16'hFFFF, 16'h0000, 16, r);
        chk(ovf_o, "R10 overflow at 16 steps", ovf_o, 1);
        chk(r == 32'hFFFF_FFFF, "R10 register after overflow", r, 32'hFFFFFFFF);

        // R11: single-step operation
        a = 16'h6D2B; d = 16'h0456;
        launch(a, d, 5, 1'b1);
        chk(quot_o == a && rem_o == 0, "R2 loaded before first step", {rem_o, quot_o}, a);
        c0 = carry_o; v0 = ovf_o;
        repeat (4) @(negedge clk);
        chk(busy_o && quot_o == a && rem_o == 0, "R11 waits without step", {busy_o, rem_o, quot_o}, {1'b1, 16'h0, a});
        chk(carry_o == c0 && ovf_o == v0, "R11 flags wait", {carry_o, ovf_o}, {c0, v0});
        m = {2'b00, 16'h0000, a};
        for (int s = 1; s <= 5; s++) begin
            stp = 1'b1;
            @(negedge clk);
            stp = 1'b0;
            m = mstep(m[31:0], d);
            chk({rem_o, quot_o} == m[31:0], "R11 one step per pulse", {rem_o, quot_o}, m[31:0]);
            chk(carry_o == m[32], "R9 carry per step", carry_o, m[32]);
            chk(done_o == (s == 5), "R11 done after last pulse", done_o, s == 5);
            if (s < 5) begin
                @(negedge clk);
                chk({rem_o, quot_o} == m[31:0], "R11 hold between pulses", {rem_o, quot_o}, m[31:0]);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule